// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds a small bank of one-bit semaphore latches that two ports share, so that software on either side can reserve a common resource without a lock held in main memory. Each port reaches the bank through its own semaphore select strobe. A few low address bits pick a latch, and an ordinary write or read command acts on it. Writing a zero on data bit 0 asks for the token, and writing a one gives it back.

Every latch tracks which port owns it, if either does. It also remembers a request from the side that does not own it. When the owner releases the token, a waiting request takes it over in the same clock edge. Each port reads its view of a latch: zero when it holds the token, one otherwise. That value is copied onto every bit of the port's data output and stays in a per-port register until the next read by that port.

Both ports share a single clock, and the model is fully synchronous. The bank lives beside a main memory whose own chip enable must be inactive during a semaphore access.

Top module: `sem_token_bank`

## Requirements
- R1: The bank has NUM_SEM (default 8) latches, picked by address bits [2:0]. Address bits above those have no effect on a semaphore access.
- R2: A write carries a request when wdata[0] is 0 and a release when wdata[0] is 1. All other data bits are ignored. A request from the port that already owns the latch changes nothing.
- R3: A free latch reads 1 on both ports. An owned latch reads 0 on the owning port and 1 on the other port. A read issued in cycle N appears on rdata after the clock edge that ends cycle N, and it shows the state from before any write made in that same cycle.
- R4: A request from the non-owning port leaves both ports' read values unchanged. It is recorded as pending.
- R5: When the owner releases a latch with a request pending, the other port becomes owner at that edge. With nothing pending, the latch becomes free. A release from the non-owning port cancels its own pending request.
- R6: A read drives the latch value onto every bit of the port's rdata, so rdata is either all zeros or all ones.
- R7: A port's rdata changes only on that port's reads. Writes or reads from the other port do not disturb it.
- R8: An access takes effect only when sel=1 and ce=0. With sel=0, or with sel=1 and ce=1 (a combination that is not allowed), the cycle has no effect on any latch or on rdata.
- R9: When both ports request the same free latch in the same cycle, the left port gets it and the right port's request stays pending.
- R10: After reset, every latch is free with nothing pending, and both rdata outputs are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select |
| l_ce | input | 1 | Left main-memory enable (must be 0 for a semaphore access) |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_addr | input | ADDR_W | Left address; only bits [2:0] used |
| l_wdata | input | DATA_W | Left write data; only bit 0 used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_ce | input | 1 | Right main-memory enable (must be 0 for a semaphore access) |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_addr | input | ADDR_W | Right address; only bits [2:0] used |
| r_wdata | input | DATA_W | Right write data; only bit 0 used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
A write takes effect at the edge that ends its cycle. A read returns its value at that same edge, taken from the state before that edge. A read in the cycle after a write therefore sees the write, and a read in the same cycle does not. The bench drives each cycle's inputs one time unit after a rising edge and waits for the next edge. It compares both rdata outputs with a reference model that is still in its pre-edge state, and only then advances the model. Every cycle compares both ports, so a read is checked against its new value and a cycle without a read is checked against the value held before.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sel,
  input  logic               ce,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [IDX_W-1:0]   idx,
  output logic               rd_en,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec
);
  logic access;

  // R8: only a semaphore select with the memory enable idle is an access
  assign access = sel & ~ce;
  // R1: upper address bits dropped
  assign idx    = addr[IDX_W-1:0];
  assign rd_en  = access & ~wr;

  // R2: only bit 0 of the write data is decoded
  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    logic hit;
    assign hit        = access & wr & (idx == g[IDX_W-1:0]);
    assign req_vec[g] = hit & ~wdata[0];
    assign rel_vec[g] = hit &  wdata[0];
  end
endmodule

// File: rtl/sem_latch.sv
module sem_latch
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic own_l,
  output logic own_r
);
  sem_owner_e owner_q, owner_d;
  logic       pend_q, pend_d;   // request waiting from the non-owning side
  logic       wait_r, wait_l;

  assign wait_r = (pend_q | r_req) & ~r_rel;
  assign wait_l = (pend_q | l_req) & ~l_rel;

  always_comb begin
    owner_d = owner_q;
    pend_d  = pend_q;
    unique case (owner_q)
      SEM_FREE: begin
        if (l_req) begin           // R9: left wins a tie
          owner_d = SEM_LEFT;
          pend_d  = r_req;
        end else if (r_req) begin
          owner_d = SEM_RIGHT;
          pend_d  = 1'b0;
        end
      end
      SEM_LEFT: begin
        if (l_rel) begin           // R5: hand over or free
          owner_d = wait_r ? SEM_RIGHT : SEM_FREE;
          pend_d  = 1'b0;
        end else begin
          pend_d  = wait_r;        // R4
        end
      end
      SEM_RIGHT: begin
        if (r_rel) begin
          owner_d = wait_l ? SEM_LEFT : SEM_FREE;
          pend_d  = 1'b0;
        end else begin
          pend_d  = wait_l;
        end
      end
      default: begin
        owner_d = SEM_FREE;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin               // R10
      owner_q <= SEM_FREE;
      pend_q  <= 1'b0;
    end else begin
      owner_q <= owner_d;
      pend_q  <= pend_d;
    end
  end

  assign own_l = (owner_q == SEM_LEFT);
  assign own_r = (owner_q == SEM_RIGHT);

  p_tie_left_r9: assert property (@(posedge clk) disable iff (rst)
    (!own_l && !own_r && l_req && r_req) |=> (own_l && pend_q));

  p_no_steal_r4: assert property (@(posedge clk) disable iff (rst)
    (own_l && !l_rel && r_req) |=> (own_l && pend_q));

  p_handover_r5: assert property (@(posedge clk) disable iff (rst)
    (own_l && l_rel && pend_q && !r_rel) |=> own_r);

  p_free_r5: assert property (@(posedge clk) disable iff (rst)
    (own_r && r_rel && !pend_q && !l_req) |=> (!own_l && !own_r));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] view,   // 1 = this port does not hold the token
  output logic [DATA_W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;                     // R10
    else if (rd_en) rdata <= {DATA_W{view[idx]}};    // R3, R6
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  p_fill_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rdata == '0 || rdata == '1));
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_ce,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_ce,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [IDX_W-1:0]   l_idx, r_idx;
  logic               l_rd, r_rd;
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] own_l, own_r;

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .sel(l_sel), .ce(l_ce), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
    .idx(l_idx), .rd_en(l_rd), .req_vec(l_req), .rel_vec(l_rel));

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .sel(r_sel), .ce(r_ce), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
    .idx(r_idx), .rd_en(r_rd), .req_vec(r_req), .rel_vec(r_rel));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    sem_latch u_latch (
      .clk(clk), .rst(rst),
      .l_req(l_req[g]), .l_rel(l_rel[g]),
      .r_req(r_req[g]), .r_rel(r_rel[g]),
      .own_l(own_l[g]), .own_r(own_r[g]));
  end

  sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd), .idx(l_idx), .view(~own_l), .rdata(l_rdata));

  sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd), .idx(r_idx), .view(~own_r), .rdata(r_rdata));

  p_one_owner_r3: assert property (@(posedge clk) disable iff (rst)
    (own_l & own_r) == '0);

  p_ignore_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    (l_ce && r_ce) |=> ($stable(own_l) && $stable(own_r)));
endmodule

// File: tb/sem_token_bank_tb_top.sv
`timescale 1ns/1ps
module sem_token_bank_tb_top;
  localparam int NS = 8, AW = 16, DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic l_sel, l_ce, l_wr, r_sel, r_ce, r_wr;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  always #4 clk = ~clk;

  sem_token_bank #(.NUM_SEM(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  // reference state: 0 free, 1 left, 2 right
  int          own_m [NS];
  bit          pend_m[NS];
  logic [DW-1:0] exp_l, exp_r;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic view_bit(int own, bit left);
    return left ? (own != 1) : (own != 2);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic set_l(bit s, bit c, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    l_sel = s; l_ce = c; l_wr = w; l_addr = a; l_wdata = d;
  endtask
  task automatic set_r(bit s, bit c, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    r_sel = s; r_ce = c; r_wr = w; r_addr = a; r_wdata = d;
  endtask

  // advance one clock: predict, compare, then update the model
  task automatic tick(string tag);
    bit la, ra;
    int li, ri;
    la = l_sel && !l_ce; ra = r_sel && !r_ce;
    li = int'(l_addr[2:0]); ri = int'(r_addr[2:0]);
    if (la && !l_wr) exp_l = {DW{view_bit(own_m[li], 1)}};
    if (ra && !r_wr) exp_r = {DW{view_bit(own_m[ri], 0)}};
    @(posedge clk); #1;
    chk({tag, (la && !l_wr) ? " R3 left" : " R7 left hold"}, l_rdata, exp_l);
    chk({tag, (ra && !r_wr) ? " R3 right" : " R7 right hold"}, r_rdata, exp_r);
    for (int i = 0; i < NS; i++) begin
      bit lq, lr, rq, rr, wr_, wl_;
      lq = la && l_wr && li == i && !l_wdata[0];
      lr = la && l_wr && li == i &&  l_wdata[0];
      rq = ra && r_wr && ri == i && !r_wdata[0];
      rr = ra && r_wr && ri == i &&  r_wdata[0];
      wr_ = (pend_m[i] || rq) && !rr;
      wl_ = (pend_m[i] || lq) && !lr;
      case (own_m[i])
        0: if (lq) begin own_m[i] = 1; pend_m[i] = rq; end
           else if (rq) begin own_m[i] = 2; pend_m[i] = 0; end
        1: if (lr) begin own_m[i] = wr_ ? 2 : 0; pend_m[i] = 0; end
           else pend_m[i] = wr_;
        default: if (rr) begin own_m[i] = wl_ ? 1 : 0; pend_m[i] = 0; end
           else pend_m[i] = wl_;
      endcase
    end
  endtask

  task automatic idle(); set_l(0,0,0,'0,'0); set_r(0,0,0,'0,'0); endtask
  task automatic rd_both(int i, string tag);
    set_l(1,0,0,AW'(i),'0); set_r(1,0,0,AW'(i),'0); tick(tag); idle();
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) begin own_m[i] = 0; pend_m[i] = 0; end
    exp_l = '1; exp_r = '1;
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0; #1;
    chk("R10 reset left", l_rdata, '1);
    chk("R10 reset right", r_rdata, '1);
    rd_both(5, "R10 free after reset");

    // directed ownership walk on latch 2
    set_l(1,0,1,16'h0002,16'hFFFE); tick("R2 left request"); idle();
    rd_both(2, "R3 left owns");
    set_r(1,0,1,16'h0002,16'h0000); tick("R4 right request"); idle();
    rd_both(2, "R4 unchanged");
    set_l(1,0,1,16'h0002,16'h0001); tick("R5 left release"); idle();
    rd_both(2, "R5 handover");
    set_l(1,0,1,16'h0002,16'h0000); tick("R4 left waits"); idle();
    set_r(1,0,1,16'h0002,16'h0001); tick("R5 right release"); idle();
    rd_both(2, "R5 handover to left");
    set_l(1,0,1,16'h0002,16'h0001); tick("R5 free"); idle();
    rd_both(2, "R5 free read");

    // R9 tie, upper address bits differ (R1)
    set_l(1,0,1,16'hA003,16'h5550); set_r(1,0,1,16'h3FF3,16'h0000); tick("R9 tie"); idle();
    rd_both(3, "R9 left wins");
    set_r(1,0,1,16'h0003,16'h0001); tick("R5 right cancels"); idle();
    set_l(1,0,1,16'h0003,16'h0001); tick("R5 release no waiter"); idle();
    rd_both(3, "R5 free after cancel");

    // R8 illegal and unselected writes
    set_l(1,1,1,16'h0004,16'h0000); set_r(0,0,1,16'h0004,16'h0000); tick("R8 ignored"); idle();
    rd_both(4, "R8 still free");
    set_l(1,1,0,16'h0004,16'h0000); tick("R8 illegal read hold"); idle();

    // R3 same-cycle read sees old state; R7 other port write does not disturb
    set_l(1,0,1,16'h0006,16'h0000); set_r(1,0,0,16'h0006,'0); tick("R3 read before write"); idle();
    set_r(1,0,1,16'h0006,16'h0000); tick("R7 left holds"); idle();
    rd_both(6, "R3 after write");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      set_l($urandom_range(3) != 0, $urandom_range(9) == 0, $urandom_range(1),
            AW'($urandom), DW'($urandom));
      set_r($urandom_range(3) != 0, $urandom_range(9) == 0, $urandom_range(1),
            AW'($urandom), DW'($urandom));
      if ($urandom_range(1)) begin l_addr[2:0] = 3'd1; r_addr[2:0] = 3'd1; end
      tick("R1 random");
    end
    idle(); tick("final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule